// File: doc/BRIEF.md
# I2C Master Clock Generator and Arbitration Monitor

This block generates the serial clock for an I2C master and keeps it in step with any other master sharing the bus. It never drives a line high. It only asserts drive-low enables, `scl_pull` and `sda_pull`, which the pad logic turns into open-drain pulls. It reads the real bus levels back through `scl_in` and `sda_in`, which are already synchronized and filtered. The low phase ends only when the block releases SCL. The high phase is counted only once SCL is actually seen high. Any external pull-down during the high phase starts a fresh low phase at once. Because of this, the bus clock follows the wired-AND of every device on the bus.

Each SCL high phase produces one bit-sample strobe. On that strobe, while the block acts as master transmitter and releases SDA for a 1, it compares the bus level with the bit it sent. A 0 read back means another master has won. The block then sets a sticky `arb_lost` flag, releases both lines and stops the clock generator, which leaves it as a passive receiver. A sequencer outside the block chooses the bits, START/STOP and byte framing. That sequencer uses `bit_strobe` as its shift point and `arb_clear` to resume.

Top module: `scl_arb_engine`

## Requirements
- R1: While `master_en` is 0, `scl_pull` and `bit_strobe` stay 0. If `master_en` falls while `scl_pull` is 1, `scl_pull` is 0 from the next clock cycle.
- R2: The phase length is E = max(`half_period`, 2). On a free bus, `scl_pull` stays 1 for exactly E cycles and is then 0 for exactly E+1 cycles, so the SCL period is 2E+1 clocks. At 100 MHz, E=499 gives about 100 kbit/s and E=124 gives about 400 kbit/s.
- R3: While another device holds SCL low after this block has released it, the high count does not start. After SCL is seen high, the block keeps SCL released for E more clock edges and then pulls it low.
- R4: If SCL is seen low during this block's high phase, `scl_pull` becomes 1 at the next clock edge and stays 1 for a full E cycles.
- R5: `bit_strobe` is a one-cycle pulse, at most once per high phase. It appears when the high count reaches E/2, rounded down, where the count is 0 on the first high cycle. It follows a cycle in which SCL was high. A high phase cut short before that point gives no strobe.
- R6: `sda_pull` = `master_en` AND `tx_active` AND NOT `tx_bit` AND NOT `arb_lost`. In other words, a transmitted 0 is driven low and a 1 is released.
- R7: If `bit_strobe`, `tx_active` and `tx_bit` are 1 and `sda_in` is 0 in the same cycle, `arb_lost` is 1 from the next cycle. From then on, `scl_pull` and `sda_pull` stay 0.
- R8: A low `sda_in` at the strobe does not set `arb_lost` when `tx_bit` is 0 or when `tx_active` is 0.
- R9: `arb_lost` stays 1 until `arb_clear` is sampled 1, which clears it at the next edge. When both happen in one cycle, the clear wins. After a clear with `master_en` 1, `scl_pull` is 0 for one more cycle and is 1 in the cycle after that.
- R10: Synchronous reset makes `scl_pull`, `sda_pull`, `bit_strobe` and `arb_lost` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| half_period | input | DIV_W | Clock cycles per SCL phase (values below 2 act as 2) |
| master_en | input | 1 | Master mode; 0 keeps the clock generator off |
| tx_active | input | 1 | Block is master transmitter for the current bit |
| tx_bit | input | 1 | Bit being sent on SDA |
| arb_clear | input | 1 | Clears the arbitration-lost flag |
| scl_in | input | 1 | Filtered SCL bus level |
| sda_in | input | 1 | Filtered SDA bus level |
| scl_pull | output | 1 | Drive SCL low when 1 |
| sda_pull | output | 1 | Drive SDA low when 1 |
| bit_strobe | output | 1 | One-cycle SDA sample point in the high phase |
| arb_lost | output | 1 | Sticky arbitration-lost flag |

## Verification
The clock is first run on a free bus at the minimum phase and at both standard rates. This confirms the exact low and high lengths and a single strobe per bit. A second device then holds SCL low past this block's low phase, and in another run pulls SCL low early in the high phase. These two runs separate a counter that waits for the bus from one that counts blindly. They also show whether the low phase restarts or only finishes out. For SDA, the block sends a 1 against a 0 and then sends a 0, and it also receives against a 0. These cases separate a real arbitration loss from a 0 the block drives itself and from a 0 it only reads, before a clear is applied and the restart is timed.

// File: rtl/scl_arb_pkg.sv
package scl_arb_pkg;

    // Phases of the serial clock generator
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // generator off, SCL released
        PH_LOW  = 2'd1,   // driving SCL low, counting
        PH_WAIT = 2'd2,   // released, waiting for the bus to rise
        PH_HIGH = 2'd3    // bus high, counting
    } phase_e;

endpackage

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
    import scl_arb_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] half_period,
    input  logic             run,
    input  logic             scl_in,
    output logic             scl_pull,
    output logic             bit_strobe
);

    localparam logic [DIV_W-1:0] MIN_PHASE = DIV_W'(2);

    typedef struct packed {
        phase_e           phase;
        logic [DIV_W-1:0] cnt;
        logic             strobe;
    } gen_t;

    gen_t s_d, s_q;

    logic [DIV_W-1:0] eff_len;
    logic [DIV_W-1:0] last_cnt;
    logic [DIV_W-1:0] tap_cnt;

    always_comb begin
        eff_len  = (half_period < MIN_PHASE) ? MIN_PHASE : half_period;
        last_cnt = eff_len - DIV_W'(1);
        tap_cnt  = (eff_len >> 1) - DIV_W'(1);

        s_d        = s_q;
        s_d.strobe = 1'b0;

        if (!run) begin
            s_d.phase = PH_IDLE;
            s_d.cnt   = '0;
        end else begin
            unique case (s_q.phase)
                PH_IDLE: begin
                    s_d.phase = PH_LOW;
                    s_d.cnt   = '0;
                end
                PH_LOW: begin
                    if (s_q.cnt >= last_cnt) begin
                        s_d.phase = PH_WAIT;
                        s_d.cnt   = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + DIV_W'(1);
                    end
                end
                PH_WAIT: begin
                    // high count starts only once the wired-AND bus is high
                    if (scl_in) begin
                        s_d.phase = PH_HIGH;
                        s_d.cnt   = '0;
                    end
                end
                PH_HIGH: begin
                    if (!scl_in) begin
                        // another device ended the high phase: new low phase
                        s_d.phase = PH_LOW;
                        s_d.cnt   = '0;
                    end else begin
                        if (s_q.cnt == tap_cnt) s_d.strobe = 1'b1;
                        if (s_q.cnt >= last_cnt) begin
                            s_d.phase = PH_LOW;
                            s_d.cnt   = '0;
                        end else begin
                            s_d.cnt = s_q.cnt + DIV_W'(1);
                        end
                    end
                end
                default: begin
                    s_d.phase = PH_IDLE;
                    s_d.cnt   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '{phase: PH_IDLE, cnt: '0, strobe: 1'b0};
        else     s_q <= s_d;
    end

    assign scl_pull   = (s_q.phase == PH_LOW);
    assign bit_strobe = s_q.strobe;

    // R1
    gen_off_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> !scl_pull);

    // R2
    low_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run && s_q.phase == PH_LOW && s_q.cnt < last_cnt) |=> scl_pull);

    // R3
    wait_bus_chk: assert property (@(posedge clk) disable iff (rst)
        (run && s_q.phase == PH_WAIT && !scl_in) |=> (s_q.phase == PH_WAIT));

    // R4
    early_low_chk: assert property (@(posedge clk) disable iff (rst)
        (run && s_q.phase == PH_HIGH && !scl_in) |=> scl_pull);

    // R5
    strobe_high_chk: assert property (@(posedge clk) disable iff (rst)
        bit_strobe |-> $past(scl_in));

    // R5
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        bit_strobe |=> !bit_strobe);

endmodule

// File: rtl/arb_watch.sv
module arb_watch (
    input  logic clk,
    input  logic rst,
    input  logic sample,
    input  logic tx_active,
    input  logic tx_bit,
    input  logic sda_in,
    input  logic arb_clear,
    output logic arb_lost
);

    logic lost_d, lost_q;
    logic mismatch;

    always_comb begin
        mismatch = sample && tx_active && tx_bit && !sda_in;
        if (arb_clear)     lost_d = 1'b0;
        else if (mismatch) lost_d = 1'b1;
        else               lost_d = lost_q;
    end

    always_ff @(posedge clk) begin
        if (rst) lost_q <= 1'b0;
        else     lost_q <= lost_d;
    end

    assign arb_lost = lost_q;

    // R7
    loss_set_chk: assert property (@(posedge clk) disable iff (rst)
        (sample && tx_active && tx_bit && !sda_in && !arb_clear) |=> arb_lost);

    // R9
    loss_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (arb_lost && !arb_clear) |=> arb_lost);

    // R9
    loss_clear_chk: assert property (@(posedge clk) disable iff (rst)
        arb_clear |=> !arb_lost);

endmodule

// File: rtl/scl_arb_engine.sv
module scl_arb_engine #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] half_period,
    input  logic             master_en,
    input  logic             tx_active,
    input  logic             tx_bit,
    input  logic             arb_clear,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             scl_pull,
    output logic             sda_pull,
    output logic             bit_strobe,
    output logic             arb_lost
);

    logic gen_run;

    assign gen_run = master_en && !arb_lost;

    scl_phase_gen #(
        .DIV_W(DIV_W)
    ) gen_i (
        .clk        (clk),
        .rst        (rst),
        .half_period(half_period),
        .run        (gen_run),
        .scl_in     (scl_in),
        .scl_pull   (scl_pull),
        .bit_strobe (bit_strobe)
    );

    arb_watch arb_i (
        .clk      (clk),
        .rst      (rst),
        .sample   (bit_strobe),
        .tx_active(tx_active),
        .tx_bit   (tx_bit),
        .sda_in   (sda_in),
        .arb_clear(arb_clear),
        .arb_lost (arb_lost)
    );

    assign sda_pull = master_en && tx_active && !tx_bit && !arb_lost;

    // R7
    lost_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        arb_lost |=> !scl_pull);

    // R1
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !master_en |=> (!scl_pull && !bit_strobe));

endmodule

// File: tb/scl_arb_engine_tb_top.sv
`timescale 1ns/1ps
module scl_arb_engine_tb_top;

    localparam int DIV_W = 16;
    localparam int CAP   = 5000;

    logic             clk = 1'b0;
    logic             rst;
    logic [DIV_W-1:0] half_period;
    logic             master_en, tx_active, tx_bit, arb_clear;
    logic             other_scl, other_sda;
    logic             scl_bus, sda_bus;
    logic             scl_pull, sda_pull, bit_strobe, arb_lost;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    // wired-AND bus with a second device
    assign scl_bus = ~(scl_pull | other_scl);
    assign sda_bus = ~(sda_pull | other_sda);

    scl_arb_engine #(.DIV_W(DIV_W)) dut_i (
        .clk(clk), .rst(rst), .half_period(half_period),
        .master_en(master_en), .tx_active(tx_active), .tx_bit(tx_bit),
        .arb_clear(arb_clear), .scl_in(scl_bus), .sda_in(sda_bus),
        .scl_pull(scl_pull), .sda_pull(sda_pull),
        .bit_strobe(bit_strobe), .arb_lost(arb_lost)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; master_en = 1'b0; tx_active = 1'b0; tx_bit = 1'b1;
        arb_clear = 1'b0; other_scl = 1'b0; other_sda = 1'b0; half_period = 16'd6;
        tick(3);
        rst = 1'b0;
        tick(1);
    endtask

    // returns at a negedge where scl_pull has just been seen rising
    task automatic wait_pull_rise();
        int k = 0;
        while (scl_pull && k < CAP) begin @(negedge clk); k++; end
        while (!scl_pull && k < CAP) begin @(negedge clk); k++; end
    endtask

    task automatic wait_strobe();
        int k = 0;
        while (!bit_strobe && k < CAP) begin @(negedge clk); k++; end
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; master_en = 1'b0; tx_active = 1'b0; tx_bit = 1'b1;
        arb_clear = 1'b0; other_scl = 1'b0; other_sda = 1'b0; half_period = 16'd6;
        tick(3);
        // R10
        chk("R10", "scl_pull in reset", int'(scl_pull), 0);
        chk("R10", "sda_pull in reset", int'(sda_pull), 0);
        chk("R10", "bit_strobe in reset", int'(bit_strobe), 0);
        chk("R10", "arb_lost in reset", int'(arb_lost), 0);
        rst = 1'b0;
        tick(1);
    endtask

    task automatic t_disabled();
        int pulls = 0;
        int strobes = 0;
        do_reset();
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (scl_pull) pulls++;
            if (bit_strobe) strobes++;
        end
        // R1
        chk("R1", "scl pulls while disabled", pulls, 0);
        chk("R1", "strobes while disabled", strobes, 0);
        master_en = 1'b1;
        wait_pull_rise();
        master_en = 1'b0;
        @(negedge clk);
        chk("R1", "scl_pull after master_en drop", int'(scl_pull), 0);
    endtask

    // free bus timing for one bit
    task automatic t_free(input int h, input int e);
        int n_l = 0;
        int n_h = 0;
        int strobes = 0;
        do_reset();
        half_period = DIV_W'(h);
        master_en = 1'b1;
        wait_pull_rise();
        while (scl_pull && n_l < CAP) begin n_l++; @(negedge clk); end
        while (!scl_pull && n_h < CAP) begin
            n_h++;
            if (bit_strobe) strobes++;
            @(negedge clk);
        end
        // R2
        chk("R2", $sformatf("low length h=%0d", h), n_l, e);
        chk("R2", $sformatf("high length h=%0d", h), n_h, e + 1);
        // R5
        chk("R5", $sformatf("strobes per bit h=%0d", h), strobes, 1);
    endtask

    task automatic t_stretch();
        int n_l = 0;
        int n_h = 0;
        int strobes = 0;
        do_reset();
        half_period = 16'd6;
        master_en = 1'b1;
        wait_pull_rise();
        other_scl = 1'b1;
        while (scl_pull && n_l < CAP) begin n_l++; @(negedge clk); end
        chk("R2", "own low length under stretch", n_l, 6);
        tick(8);
        // R3
        chk("R3", "scl_pull while bus held low", int'(scl_pull), 0);
        chk("R3", "bus still low while held", int'(scl_bus), 0);
        other_scl = 1'b0;
        @(negedge clk);
        while (scl_bus && n_h < CAP) begin
            n_h++;
            if (bit_strobe) strobes++;
            @(negedge clk);
        end
        chk("R3", "high edges after bus release", n_h, 6);
        chk("R5", "strobe after stretched low", strobes, 1);
    endtask

    task automatic t_early_low();
        int n_l = 0;
        int strobes = 0;
        do_reset();
        half_period = 16'd6;
        master_en = 1'b1;
        wait_pull_rise();
        while (scl_pull && n_l < CAP) begin n_l++; @(negedge clk); end
        if (bit_strobe) strobes++;
        @(negedge clk);
        if (bit_strobe) strobes++;
        @(negedge clk);
        if (bit_strobe) strobes++;
        other_scl = 1'b1;
        @(negedge clk);
        if (bit_strobe) strobes++;
        // R4
        chk("R4", "pull right after external low", int'(scl_pull), 1);
        other_scl = 1'b0;
        n_l = 0;
        while (scl_pull && n_l < CAP) begin n_l++; @(negedge clk); end
        chk("R4", "restarted low length", n_l, 6);
        // R5
        chk("R5", "no strobe in cut high phase", strobes, 0);
    endtask

    task automatic t_arb_loss_and_clear();
        int pulls = 0;
        do_reset();
        half_period = 16'd6;
        tx_active = 1'b1; tx_bit = 1'b1; other_sda = 1'b1;
        master_en = 1'b1;
        chk("R6", "sda released for a 1", int'(sda_pull), 0);
        wait_strobe();
        // R7
        chk("R7", "strobe reached", int'(bit_strobe), 1);
        chk("R7", "no loss before sample", int'(arb_lost), 0);
        @(negedge clk);
        chk("R7", "loss after mismatched sample", int'(arb_lost), 1);
        chk("R7", "sda released after loss", int'(sda_pull), 0);
        other_sda = 1'b0;
        tx_bit = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (scl_pull) pulls++;
        end
        chk("R7", "scl pulls after loss", pulls, 0);
        chk("R6", "sda_pull for a 0 after loss", int'(sda_pull), 0);
        // R9
        chk("R9", "flag still set", int'(arb_lost), 1);
        tx_bit = 1'b1;
        arb_clear = 1'b1;
        @(negedge clk);
        arb_clear = 1'b0;
        chk("R9", "flag cleared", int'(arb_lost), 0);
        chk("R9", "scl_pull one cycle after clear", int'(scl_pull), 0);
        @(negedge clk);
        chk("R9", "scl_pull two cycles after clear", int'(scl_pull), 1);
    endtask

    task automatic t_clear_priority();
        do_reset();
        half_period = 16'd6;
        tx_active = 1'b1; tx_bit = 1'b1; other_sda = 1'b1;
        master_en = 1'b1;
        wait_strobe();
        arb_clear = 1'b1;
        @(negedge clk);
        arb_clear = 1'b0;
        // R9
        chk("R9", "clear wins over same-cycle loss", int'(arb_lost), 0);
    endtask

    task automatic t_no_loss();
        do_reset();
        half_period = 16'd6;
        tx_active = 1'b1; tx_bit = 1'b0;
        // R6
        chk("R6", "sda_pull disabled master", int'(sda_pull), 0);
        master_en = 1'b1;
        @(negedge clk);
        chk("R6", "sda driven for a 0", int'(sda_pull), 1);
        for (int b = 0; b < 3; b++) begin
            wait_strobe();
            @(negedge clk);
        end
        // R8
        chk("R8", "own 0 is no loss", int'(arb_lost), 0);
        tx_active = 1'b0; tx_bit = 1'b1; other_sda = 1'b1;
        @(negedge clk);
        chk("R6", "sda released when receiving", int'(sda_pull), 0);
        for (int b = 0; b < 3; b++) begin
            wait_strobe();
            @(negedge clk);
        end
        chk("R8", "receive against 0 is no loss", int'(arb_lost), 0);
        other_sda = 1'b0;
    endtask

    initial begin
        t_reset();
        t_disabled();
        t_free(6, 6);
        t_free(0, 2);
        t_free(499, 499);
        t_free(124, 124);
        t_stretch();
        t_early_low();
        t_arb_loss_and_clear();
        t_clear_priority();
        t_no_loss();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule